// File: doc/BRIEF.md
# Two-Wire Register Access Target

This block lets a host on a two-wire serial bus (I2C) read and write a bank of 16-bit registers. Both bus lines are sampled with the local system clock. The block finds start, repeated-start and stop conditions and compares the first byte after a start with a fixed 7-bit device address. It acknowledges only when that address matches. The address byte's last bit selects the direction: 0 means write and 1 means read.

A write sends two pointer bytes, then data bytes in pairs. Each pair becomes one 16-bit register write. A read returns the register the pointer selects, high byte first, and goes on register by register until the host refuses a byte. The pointer advances after every 16-bit access and stops at a configurable highest register instead of wrapping. Writes past that register are dropped, and reads past it keep returning it.

The register bank sits outside the block. It sees a pointer-driven address, a 16-bit write bus with a one-cycle strobe, and a 16-bit read bus that the block samples when a high byte starts.

Top module: `i2c_regport_target`

## Requirements
- R1: After reset the block does not pull SDA (`sda_oe` = 0) and does not strobe `reg_we`.
- R2: A start, or a repeated start, followed by a byte whose bits 7:1 equal `DEV_ADDR` gets an acknowledge (SDA low in the ninth clock). Bit 0 of that byte is 0 for a write and 1 for a read.
- R3: A device byte that does not match gets no acknowledge. Every later byte up to the next start is then left unacknowledged and writes nothing.
- R4: In a write, the first pointer byte supplies address bits 9:8 from its bits 1:0, and its bits 7:2 are ignored. The second pointer byte supplies bits 7:0. A loaded value above `MAX_ADDR` is clamped to `MAX_ADDR`.
- R5: Each pair of data bytes writes {first byte, second byte} to the register at the pointer. Every pointer byte and every data byte is acknowledged.
- R6: The pointer increments by one after each 16-bit write and after each 16-bit read, so a later transaction with no new pointer continues from there.
- R7: A write at `MAX_ADDR` takes effect. Later pairs are acknowledged but dropped until new pointer bytes are loaded.
- R8: A single data byte still waiting for its partner when a stop or repeated start arrives writes no register.
- R9: Read data goes out high byte first and MSB first. Each register is sampled when its high byte begins. Reading continues while the host acknowledges, and a no-acknowledge ends the transfer.
- R10: Once the pointer is at `MAX_ADDR`, every further read pair returns that register's contents.
- R11: A read returns the register that a preceding write set, whether that write ended in a repeated start or in a stop.
- R12: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |
| reg_addr | output | AW | Register address, the current pointer |
| reg_wdata | output | 16 | Data for the register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 16 | Contents of the register at `reg_addr` |

## Verification
Some properties are checked on every cycle. SDA only moves while SCL is low, the pointer never exceeds the top register and never steps by more than one except on a load, a blocked pointer never lets a write through, and a write only fires on the second byte of a pair. The bench scenarios are needed for everything that depends on byte contents across a transaction. That covers address matching and refusal, pointer assembly with its ignored bits and clamping, the pairing of data bytes, the dropped lone byte, the continuation of the pointer across transactions, and the repeated last register at saturation.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
    localparam int REG_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } st_e;

    typedef enum logic [1:0] {
        RK_DEV,
        RK_AHI,
        RK_ALO,
        RK_DAT
    } rk_e;
endpackage

// File: rtl/i2cr_sampler.sv
module i2cr_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [1:0] scl_sy;
        logic [1:0] sda_sy;
        logic       scl_p;
        logic       sda_p;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d        = smp_q;
        smp_d.scl_sy = {smp_q.scl_sy[0], scl_i};
        smp_d.sda_sy = {smp_q.sda_sy[0], sda_i};
        smp_d.scl_p  = smp_q.scl_sy[1];
        smp_d.sda_p  = smp_q.sda_sy[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign scl_lvl  = smp_q.scl_sy[1];
    assign sda_lvl  = smp_q.sda_sy[1];
    assign scl_rise = scl_lvl & ~smp_q.scl_p;
    assign scl_fall = ~scl_lvl & smp_q.scl_p;
    assign start_ev = scl_lvl & smp_q.scl_p & smp_q.sda_p & ~sda_lvl;
    assign stop_ev  = scl_lvl & smp_q.scl_p & ~smp_q.sda_p & sda_lvl;
endmodule

// File: rtl/i2cr_ptr.sv
module i2cr_ptr #(
    parameter int            AW       = 10,
    parameter logic [AW-1:0] MAX_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          rd_step,
    input  logic          wr_step,
    output logic [AW-1:0] ptr,
    output logic          wr_block
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          blk;
    } pst_t;

    pst_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (load) begin
            p_d.ptr = (load_val > MAX_ADDR) ? MAX_ADDR : load_val;
            p_d.blk = 1'b0;
        end else if (rd_step) begin
            if (p_q.ptr != MAX_ADDR) p_d.ptr = p_q.ptr + AW'(1);
        end else if (wr_step) begin
            if (p_q.ptr != MAX_ADDR) p_d.ptr = p_q.ptr + AW'(1);
            else                     p_d.blk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign ptr      = p_q.ptr;
    assign wr_block = p_q.blk;

    // R4
    ptr_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.ptr <= MAX_ADDR);

    // R6
    ptr_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> (p_q.ptr == $past(p_q.ptr)) || (p_q.ptr == $past(p_q.ptr) + AW'(1)));

    // R10
    ptr_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rd_step && p_q.ptr == MAX_ADDR) |=> p_q.ptr == MAX_ADDR);
endmodule

// File: rtl/i2c_regport_target.sv
module i2c_regport_target #(
    parameter logic [6:0]    DEV_ADDR = 7'h3A,
    parameter int            AW       = 10,
    parameter logic [AW-1:0] MAX_ADDR = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_oe,
    output logic [AW-1:0]             reg_addr,
    output logic [i2cr_pkg::REG_W-1:0] reg_wdata,
    output logic                      reg_we,
    input  logic [i2cr_pkg::REG_W-1:0] reg_rdata
);
    import i2cr_pkg::*;

    localparam int HIW = AW - 8;

    typedef struct packed {
        st_e          st;
        rk_e          kind;
        logic [3:0]   bitcnt;
        logic [7:0]   shreg;
        logic [7:0]   hold;
        logic         half;
        logic         rw;
        logic         nack;
        logic [HIW-1:0] ahi;
        logic [7:0]   txsh;
        logic [7:0]   txlo;
        logic         sda_oe;
    } ctl_t;

    ctl_t q, d;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic ld, rd_step, wr_step, we, wr_block;
    logic [AW-1:0] ptr;

    i2cr_sampler smp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2cr_ptr #(.AW(AW), .MAX_ADDR(MAX_ADDR)) ptr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val ({q.ahi, q.shreg}),
        .rd_step  (rd_step),
        .wr_step  (wr_step),
        .ptr      (ptr),
        .wr_block (wr_block)
    );

    always_comb begin
        d       = q;
        ld      = 1'b0;
        rd_step = 1'b0;
        wr_step = 1'b0;
        we      = 1'b0;
        if (start_ev) begin
            d.st     = ST_RX;
            d.kind   = RK_DEV;
            d.bitcnt = '0;
            d.half   = 1'b0;
            d.nack   = 1'b0;
            d.sda_oe = 1'b0;
        end else if (stop_ev) begin
            d.st     = ST_IDLE;
            d.half   = 1'b0;
            d.sda_oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.shreg  = {q.shreg[6:0], sda_lvl};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.bitcnt = '0;
                        d.st     = ST_ACK;
                        d.sda_oe = 1'b1;
                        case (q.kind)
                            RK_DEV: begin
                                if (q.shreg[7:1] == DEV_ADDR) begin
                                    d.rw = q.shreg[0];
                                end else begin
                                    d.st     = ST_IDLE;
                                    d.sda_oe = 1'b0;
                                end
                            end
                            RK_AHI: d.ahi = q.shreg[HIW-1:0];
                            RK_ALO: ld = 1'b1;
                            default: begin
                                if (!q.half) begin
                                    d.hold = q.shreg;
                                    d.half = 1'b1;
                                end else begin
                                    d.half = 1'b0;
                                    if (!wr_block) begin
                                        we      = 1'b1;
                                        wr_step = 1'b1;
                                    end
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        d.bitcnt = '0;
                        d.st     = ST_RX;
                        case (q.kind)
                            RK_DEV: begin
                                if (q.rw) begin
                                    d.txsh    = reg_rdata[15:8];
                                    d.txlo    = reg_rdata[7:0];
                                    d.sda_oe  = ~reg_rdata[15];
                                    d.half    = 1'b1;
                                    d.st      = ST_TX;
                                    rd_step   = 1'b1;
                                end else begin
                                    d.kind = RK_AHI;
                                end
                            end
                            RK_AHI: d.kind = RK_ALO;
                            RK_ALO: begin
                                d.kind = RK_DAT;
                                d.half = 1'b0;
                            end
                            default: d.kind = RK_DAT;
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            d.sda_oe = 1'b0;
                            d.nack   = 1'b0;
                            d.st     = ST_MACK;
                        end else if (q.bitcnt != 4'd0) begin
                            d.txsh   = {q.txsh[6:0], 1'b0};
                            d.sda_oe = ~q.txsh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.nack = sda_lvl;
                    end else if (scl_fall) begin
                        d.bitcnt = '0;
                        if (q.nack) begin
                            d.st     = ST_IDLE;
                            d.sda_oe = 1'b0;
                        end else if (q.half) begin
                            d.txsh   = q.txlo;
                            d.sda_oe = ~q.txlo[7];
                            d.half   = 1'b0;
                            d.st     = ST_TX;
                        end else begin
                            d.txsh   = reg_rdata[15:8];
                            d.txlo   = reg_rdata[7:0];
                            d.sda_oe = ~reg_rdata[15];
                            d.half   = 1'b1;
                            d.st     = ST_TX;
                            rd_step  = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= RK_DEV;
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = q.sda_oe;
    assign reg_addr  = ptr;
    assign reg_wdata = {q.hold, q.shreg};
    assign reg_we    = we;

    // R12
    sda_edge_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sda_oe != $past(q.sda_oe)) |-> !$past(scl_lvl));

    // R7
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |-> !reg_we);

    // R5
    pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (q.kind == RK_DAT && q.half && scl_fall));

    // R3
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !sda_oe);
endmodule

// File: tb/i2c_regport_target_tb.sv
module i2c_regport_target_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          Q          = 8;
    localparam logic [6:0]  DEV        = 7'h3A;
    localparam int          MAXA       = 47;

    typedef struct packed {
        logic [9:0]  a;
        logic [15:0] d;
    } wr_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, reg_we;
    logic [9:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic sda_line;

    logic [15:0] mem     [64];
    logic [15:0] exp_mem [64];
    wr_t exp_wq[$];
    int checks = 0;
    int errors = 0;
    int bptr   = 0;
    bit blk    = 0;
    int r12_viol = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr[5:0]];

    i2c_regport_target #(.DEV_ADDR(DEV), .AW(10), .MAX_ADDR(10'(MAXA))) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    always @(posedge clk) if (reg_we) mem[reg_addr[5:0]] <= reg_wdata;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected register writes (R5, R7, R8, R3)
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_wq.size() == 0) begin
                chk(1'b0, "R3/R7/R8 unexpected write", {6'd0, reg_addr, reg_wdata}, 32'd0);
            end else begin
                wr_t e;
                e = exp_wq.pop_front();
                chk(reg_addr == e.a && reg_wdata == e.d, "R5 write",
                    {6'd0, reg_addr, reg_wdata}, {6'd0, e.a, e.d});
            end
        end
    end

    // R12 watch: master-side SCL high for the previous cycle and SDA drive moves
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;
    always @(negedge clk) begin
        if (rst_n && sda_oe != prev_oe && prev_scl) r12_viol++;
        prev_oe  <= sda_oe;
        prev_scl <= scl_m;
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; w(Q);
        scl_m = 1'b1; w(2*Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        b = sda_line; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo, input string req);
        logic a;
        int   full;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        chk(a, "R2 write address ack", {31'd0, a}, 1);
        send_byte(hi, a);
        chk(a, {req, " pointer hi ack"}, {31'd0, a}, 1);
        send_byte(lo, a);
        chk(a, {req, " pointer lo ack"}, {31'd0, a}, 1);
        full = {22'd0, hi[1:0], lo};
        bptr = (full > MAXA) ? MAXA : full;
        blk  = 1'b0;
    endtask

    task automatic wr_pair(input logic [15:0] v, input string req);
        logic a;
        if (!blk) begin
            exp_wq.push_back('{a: 10'(bptr), d: v});
            exp_mem[bptr] = v;
            if (bptr == MAXA) blk = 1'b1;
            else              bptr++;
        end
        send_byte(v[15:8], a);
        chk(a, {req, " data hi ack"}, {31'd0, a}, 1);
        send_byte(v[7:0], a);
        chk(a, {req, " data lo ack"}, {31'd0, a}, 1);
    endtask

    task automatic start_read(input bit repeated);
        logic a;
        if (repeated) begin
            sda_m = 1'b1; w(Q);
            scl_m = 1'b1; w(Q);
            sda_m = 1'b0; w(Q);
            scl_m = 1'b0; w(Q);
        end else begin
            bus_start();
        end
        send_byte({DEV, 1'b1}, a);
        chk(a, "R2 read address ack", {31'd0, a}, 1);
    endtask

    task automatic rd_pair(input bit last, input string req);
        logic [7:0]  hb, lb;
        logic [15:0] e;
        e = exp_mem[bptr];
        recv_byte(hb, 1'b1);
        chk(hb == e[15:8], {req, " R9 high byte"}, {24'd0, hb}, {24'd0, e[15:8]});
        recv_byte(lb, !last);
        chk(lb == e[7:0], {req, " R9 low byte"}, {24'd0, lb}, {24'd0, e[7:0]});
        if (bptr != MAXA) bptr++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 16'(i * 16'h0101) ^ 16'h5A3C;
            exp_mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
        end
        w(5);
        chk(sda_oe == 1'b0, "R1 sda released in reset", {31'd0, sda_oe}, 0);
        rst_n = 1'b1;
        w(5);
        chk(sda_oe == 1'b0, "R1 sda released after reset", {31'd0, sda_oe}, 0);
        chk(reg_we == 1'b0, "R1 no write after reset", {31'd0, reg_we}, 0);

        // R3: mismatched device address
        bus_start();
        send_byte({7'h3B, 1'b0}, a);
        chk(!a, "R3 mismatch not acked", {31'd0, a}, 0);
        send_byte(8'h00, a);
        chk(!a, "R3 later byte not acked", {31'd0, a}, 0);
        send_byte(8'h05, a);
        chk(!a, "R3 later byte not acked", {31'd0, a}, 0);
        bus_stop();
        chk(sda_oe == 1'b0, "R3 bus released", {31'd0, sda_oe}, 0);

        // R4 ignored high bits, R5 pairs, R6 increments
        set_ptr(8'hFC, 8'h05, "R4");
        wr_pair(16'hBEEF, "R5");
        wr_pair(16'h1234, "R5");
        wr_pair(16'hC0DE, "R6");
        bus_stop();

        // R6 / R11: read after stop continues at the advanced pointer
        start_read(1'b0);
        rd_pair(1'b1, "R6 continue");
        bus_stop();

        // R11 repeated start, R9 multi-register stream
        set_ptr(8'h00, 8'h05, "R11");
        start_read(1'b1);
        rd_pair(1'b0, "R11");
        rd_pair(1'b0, "R9");
        rd_pair(1'b0, "R9");
        rd_pair(1'b1, "R9");
        bus_stop();

        // R8: lone byte dropped at stop
        set_ptr(8'h00, 8'd20, "R8");
        wr_pair(16'hAAAA, "R8");
        send_byte(8'h77, a);
        chk(a, "R8 lone byte ack", {31'd0, a}, 1);
        bus_stop();
        set_ptr(8'h00, 8'd21, "R8");
        start_read(1'b1);
        rd_pair(1'b1, "R8 untouched");
        bus_stop();

        // R7: write saturation
        set_ptr(8'h00, 8'd46, "R7");
        wr_pair(16'h1111, "R7");
        wr_pair(16'h2222, "R7");
        wr_pair(16'h3333, "R7 dropped");
        bus_stop();

        // R10: read saturation
        set_ptr(8'h00, 8'd46, "R10");
        start_read(1'b1);
        rd_pair(1'b0, "R10");
        rd_pair(1'b0, "R10");
        rd_pair(1'b0, "R10 repeat");
        rd_pair(1'b1, "R10 repeat");
        bus_stop();

        // R4 clamp above top register
        set_ptr(8'h03, 8'hFF, "R4 clamp");
        start_read(1'b1);
        rd_pair(1'b0, "R4 clamp");
        rd_pair(1'b1, "R4 clamp");
        bus_stop();

        // R7: reload clears block
        set_ptr(8'h00, 8'd47, "R7 reload");
        wr_pair(16'h4444, "R7 reload");
        bus_stop();
        set_ptr(8'h00, 8'd47, "R7 reload");
        start_read(1'b1);
        rd_pair(1'b1, "R7 reload");
        bus_stop();

        w(4 * Q);
        chk(exp_wq.size() == 0, "R5 all writes seen", exp_wq.size(), 0);
        chk(r12_viol == 0, "R12 sda moves only with scl low", r12_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule